// File: doc/BRIEF.md
# Sign-Magnitude Adder

This block adds two signed words that are held in sign-magnitude form. The top bit of each word is the sign, with 1 meaning negative. The bits below it hold the absolute value. The block returns their sum in the same form, together with a flag that is raised when the true sum does not fit the output.

Inside the block, each operand is first turned into a ones' complement word: when the sign is set, the magnitude bits are inverted, and when it is clear the operand passes through unchanged. With an 8-bit magnitude, this gives 255 minus the magnitude. The two words are added with the sign bits included. The carry out of the top bit is added back in at the bottom as a second, separate add stage, so the design has no combinational loop. The result is then turned back into sign-magnitude, and a negative zero is rewritten as positive zero.

The block is purely combinational and holds no registers. The width is a parameter; the default of 9 gives a sign bit plus an 8-bit magnitude.

Top module: `sm_oc_adder`

## Requirements
- R1: For every operand pair whose true sum has a magnitude of at most 2^(N-1)-1, `sum_o` encodes that sum exactly. The top bit is the sign (1 = negative) and the low N-1 bits are the magnitude.
- R2: `sum_o` never shows negative zero (sign 1 with magnitude 0). A zero result is always given as all zeros.
- R3: `ovf_o` is 1 exactly when the true sum's magnitude exceeds 2^(N-1)-1. It is always 0 when the two operand signs differ. While `ovf_o` is 1, the value of `sum_o` is undefined.
- R4: A negative-zero operand (sign 1, magnitude 0) is treated as zero. The output then equals the other operand, with negative zero given as all zeros, and `ovf_o` is 0.
- R5: When the operand signs differ and the sum is not zero, the output sign is that of the operand with the larger magnitude.
- R6: When the operand signs are equal, `ovf_o` is 0 and the sum is not zero, the output sign equals the operands' sign.
- R7: The outputs depend only on the present inputs. They settle within the same clock period in which the inputs change, and no clock edge is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand, sign-magnitude |
| b_i | input | N | Second operand, sign-magnitude |
| sum_o | output | N | Sum, sign-magnitude, negative zero normalised |
| ovf_o | output | 1 | True sum out of range |

## Verification
The assertions assume that the inputs carry no X or Z bits. They also assume that the logic has settled by the time a combinational block that reads both inputs and outputs is evaluated. They make no assumption about operand values, so negative-zero operands and operand pairs that overflow are both legal. The bench drives only fully known values, including both encodings of zero. It holds each operand pair steady for a fixed interval before it samples the outputs.

// File: rtl/smadd_pkg.sv
package smadd_pkg;

    typedef enum logic {
        SIGN_POS = 1'b0,
        SIGN_NEG = 1'b1
    } sign_e;

    localparam int unsigned DEF_WIDTH = 9;

endpackage

// File: rtl/sm_to_oc.sv
module sm_to_oc
    import smadd_pkg::*;
#(
    parameter int unsigned W = DEF_WIDTH
) (
    input  logic [W-1:0] sm_i,
    output logic [W-1:0] oc_o
);
    localparam int unsigned M = W - 1;

    typedef struct packed {
        sign_e        sign;
        logic [M-1:0] mag;
    } word_t;

    word_t in_w;
    word_t out_w;

    always_comb begin
        in_w       = word_t'(sm_i);
        out_w.sign = in_w.sign;
        out_w.mag  = in_w.mag ^ {M{in_w.sign == SIGN_NEG}};
        oc_o       = out_w;
    end

endmodule

// File: rtl/oc_adder.sv
module oc_adder
    import smadd_pkg::*;
#(
    parameter int unsigned W = DEF_WIDTH
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] s_o,
    output logic         ovf_o
);
    logic [W:0] first_sum;
    logic [W:0] wrapped_sum;
    logic       wrap_bit;

    always_comb begin
        first_sum   = {1'b0, x_i} + {1'b0, y_i};
        wrap_bit    = first_sum[W];
        wrapped_sum = {1'b0, first_sum[W-1:0]} + {{W{1'b0}}, wrap_bit};
        s_o         = wrapped_sum[W-1:0];
        ovf_o       = (x_i[W-1] == y_i[W-1]) && (s_o[W-1] != x_i[W-1]);
    end

    // R1: the fed-back carry never wraps a second time
    always_comb begin
        assert_single_wrap_R1: assert (wrapped_sum[W] == 1'b0)
            else $error("end-around add produced a second carry");
    end

endmodule

// File: rtl/oc_to_sm.sv
module oc_to_sm
    import smadd_pkg::*;
#(
    parameter int unsigned W = DEF_WIDTH
) (
    input  logic [W-1:0] oc_i,
    output logic [W-1:0] sm_o
);
    localparam int unsigned M = W - 1;

    typedef struct packed {
        sign_e        sign;
        logic [M-1:0] mag;
    } word_t;

    word_t raw;
    word_t res;

    always_comb begin
        raw     = word_t'(oc_i);
        res.mag = raw.mag ^ {M{raw.sign == SIGN_NEG}};
        if (res.mag == '0) res.sign = SIGN_POS;
        else               res.sign = raw.sign;
        sm_o    = res;
    end

endmodule

// File: rtl/sm_oc_adder.sv
module sm_oc_adder
    import smadd_pkg::*;
#(
    parameter int unsigned N = DEF_WIDTH
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] sum_o,
    output logic         ovf_o
);
    localparam int unsigned M = N - 1;
    localparam logic [N-1:0] NEG_ZERO = {1'b1, {M{1'b0}}};

    logic [N-1:0] a_oc;
    logic [N-1:0] b_oc;
    logic [N-1:0] s_oc;

    sm_to_oc #(.W(N)) u_conv_a (.sm_i(a_i), .oc_o(a_oc));
    sm_to_oc #(.W(N)) u_conv_b (.sm_i(b_i), .oc_o(b_oc));

    oc_adder #(.W(N)) u_add (
        .x_i  (a_oc),
        .y_i  (b_oc),
        .s_o  (s_oc),
        .ovf_o(ovf_o)
    );

    oc_to_sm #(.W(N)) u_back (.oc_i(s_oc), .sm_o(sum_o));

    always_comb begin
        if (a_i[N-1] != b_i[N-1]) begin
            assert_no_overflow_R3: assert (!ovf_o)
                else $error("overflow flagged on mixed-sign operands");
        end
        assert_no_negzero_R2: assert (sum_o != NEG_ZERO)
            else $error("negative zero on output");
        if (a_i == NEG_ZERO) begin
            assert_negzero_in_R4: assert (!ovf_o && sum_o == ((b_i == NEG_ZERO) ? '0 : b_i))
                else $error("negative-zero operand not treated as zero");
        end
        if (!ovf_o && a_i[N-1] == b_i[N-1] && sum_o[M-1:0] != '0) begin
            assert_same_sign_R6: assert (sum_o[N-1] == a_i[N-1])
                else $error("sign lost on same-sign addition");
        end
    end

endmodule

// File: tb/tb_sm_oc_adder.sv
module tb_sm_oc_adder;
    localparam int N = 9;
    localparam int M = N - 1;
    localparam int MAXMAG = (1 << M) - 1;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 180000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] a, b;
    logic [N-1:0] sum;
    logic         ovf;
    int           nvec = 0;
    int           nfail = 0;
    bit           done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sm_oc_adder #(.N(N)) dut (.a_i(a), .b_i(b), .sum_o(sum), .ovf_o(ovf));

    function automatic int sm_val(input logic [N-1:0] w);
        int m;
        m = int'(w[M-1:0]);
        return w[N-1] ? -m : m;
    endfunction

    task automatic fail_line(input string req, input logic [N-1:0] act, input logic [N-1:0] exp_v);
        nfail++;
        $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, a, b, act, exp_v);
    endtask

    task automatic check_vec();
        int           ref_sum, mag;
        logic [N-1:0] exp_w;
        bit           exp_ovf;
        string        tag;
        ref_sum = sm_val(a) + sm_val(b);
        mag     = (ref_sum < 0) ? -ref_sum : ref_sum;
        exp_ovf = (mag > MAXMAG);
        nvec++;
        if (ovf !== exp_ovf) begin
            fail_line("R3", {{M{1'b0}}, ovf}, {{M{1'b0}}, exp_ovf});
            return;
        end
        if (exp_ovf) return;
        exp_w = {ref_sum < 0, mag[M-1:0]};
        if (a == {1'b1, {M{1'b0}}} || b == {1'b1, {M{1'b0}}}) tag = "R4";
        else if (mag == 0) tag = "R2";
        else if (a[N-1] != b[N-1]) tag = "R5";
        else tag = "R6";
        if (sum !== exp_w) begin
            if (sum[M-1:0] === exp_w[M-1:0] && tag != "R4" && tag != "R2")
                fail_line(tag, sum, exp_w);
            else
                fail_line((tag == "R5" || tag == "R6") ? "R1" : tag, sum, exp_w);
        end
    endtask

    initial begin
        a = '0;
        b = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state and R7: outputs follow inputs with no edge
        nvec++;
        if (sum !== '0 || ovf !== 1'b0) fail_line("R7", sum, '0);
        a = 9'h005; b = 9'h003;
        #1;
        nvec++;
        if (sum !== 9'h008) fail_line("R7", sum, 9'h008);
        #2;
        for (int ia = 0; ia < (1 << N); ia++) begin
            for (int ib = 0; ib < (1 << N); ib++) begin
                a = ia[N-1:0];
                b = ib[N-1:0];
                #2;
                check_vec();
                #3;
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule